// File: doc/BRIEF.md
# Dual Data Pointer Unit

This block keeps two external-data address pointers for an 8032-style core and shows one of them at a time through the standard pointer register pair in the special-function-register space. Software picks the active pointer with a select bit in a control register. While the core never sets that bit, the block acts like an ordinary single-pointer machine.

A second control bit turns on automatic swapping. When it is set, every MOVX strobe from the core flips the selection once that access has finished. A memory-to-memory copy can then alternate between a source pointer and a destination pointer without any firmware work on the pointers. The block drives the active pointer as an address output for the external-memory path. It also answers SFR reads and writes through a plain address, write data, write strobe and read data bus.

Top module: `dptr_bank_unit`

## Requirements
- R1: After reset both pointers hold 0000h, the control register reads 00h, and the address output is 0000h.
- R2: Control bit 0 (at SFR 85h) picks the active pointer, with 0 selecting pointer 0 and 1 selecting pointer 1. Reads of 82h and 83h return the low and high byte of the active pointer.
- R3: A write to 82h replaces the low byte, and a write to 83h the high byte, of the pointer that is active in that cycle only. The other pointer keeps its value.
- R4: Control bits 7 and 5..1 always read 0, and writing them has no effect on any readable state.
- R5: With control bit 6 set, a cycle with the MOVX strobe high inverts the select bit at the end of that cycle. The address output during the strobe cycle shows the previously active pointer, and from the next cycle it shows the other pointer.
- R6: With control bit 6 clear, the MOVX strobe leaves the selection unchanged.
- R7: A control-register write in the same cycle as a toggling MOVX strobe sets the select bit to the written value, and no toggle is applied.
- R8: The address output always equals the pointer named by the current select bit.
- R9: SFR addresses other than 82h, 83h and 85h read as 00h, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sfr_addr | input | 8 | SFR address |
| sfr_wdata | input | 8 | SFR write data |
| sfr_we | input | 1 | SFR write strobe |
| movx_stb | input | 1 | High for one cycle for each MOVX access that uses the pointer |
| sfr_rdata | output | 8 | SFR read data for `sfr_addr`, combinational |
| xaddr | output | 16 | Active pointer value, used as the external address |

## Verification
The bench builds the unit with its default parameters: 8-bit SFR data, 16-bit pointers split into two byte lanes at 82h and 83h, and the control register at 85h. With these values every lane, both pointers and both control bits can be reached through the SFR bus. This includes the collisions that matter here: a control write in the same cycle as a toggling MOVX, and a pointer-byte write during a toggle, which must land in the pointer that was active before the flip.

// File: rtl/dptr_bank_pkg.sv
package dptr_bank_pkg;

   localparam int NUM_PTR      = 2;
   localparam int CTRL_SEL_BIT = 0;
   localparam int CTRL_TOG_BIT = 6;

   typedef struct packed {
      logic toggle_en;
      logic sel;
   } dptr_ctrl_t;

endpackage

// File: rtl/dptr_ctrl_reg.sv
module dptr_ctrl_reg
   import dptr_bank_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wdata,
   input  logic              movx_stb,
   output dptr_ctrl_t        ctrl
);

   generate
      if (DATA_W <= CTRL_TOG_BIT) begin : g_bad_width
         $error("dptr_ctrl_reg: DATA_W too narrow for the toggle bit");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl <= '0;
      end else if (wr_en) begin
         ctrl.sel       <= wdata[CTRL_SEL_BIT];
         ctrl.toggle_en <= wdata[CTRL_TOG_BIT];
      end else if (movx_stb && ctrl.toggle_en) begin
         ctrl.sel <= ~ctrl.sel;
      end
   end

   assert_toggle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (movx_stb && ctrl.toggle_en && !wr_en) |=> (ctrl.sel != $past(ctrl.sel)));

   assert_no_toggle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl.toggle_en && !wr_en) |=> $stable(ctrl.sel));

   assert_sw_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (ctrl.sel == $past(wdata[CTRL_SEL_BIT])));

endmodule

// File: rtl/dptr_store.sv
module dptr_store #(
   parameter int NUM_PTR = 2,
   parameter int DATA_W  = 8,
   parameter int PTR_W   = 16,
   localparam int LANES  = PTR_W / DATA_W,
   localparam int SEL_W  = (NUM_PTR > 1) ? $clog2(NUM_PTR) : 1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [SEL_W-1:0]             sel,
   input  logic [LANES-1:0]             lane_we,
   input  logic [DATA_W-1:0]            wdata,
   output logic [NUM_PTR-1:0][PTR_W-1:0] ptrs
);

   generate
      if (PTR_W % DATA_W != 0) begin : g_bad_lanes
         $error("dptr_store: PTR_W must be a multiple of DATA_W");
      end
      if (NUM_PTR < 2) begin : g_bad_count
         $error("dptr_store: at least two pointers are required");
      end
   endgenerate

   for (genvar p = 0; p < NUM_PTR; p++) begin : g_ptr
      for (genvar b = 0; b < LANES; b++) begin : g_lane
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               ptrs[p][b*DATA_W +: DATA_W] <= '0;
            else if (lane_we[b] && (sel == SEL_W'(p)))
               ptrs[p][b*DATA_W +: DATA_W] <= wdata;
         end
      end

      assert_unsel_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (sel != SEL_W'(p)) |=> $stable(ptrs[p]));
   end

endmodule

// File: rtl/dptr_rd_mux.sv
module dptr_rd_mux #(
   parameter int              ADDR_W    = 8,
   parameter int              DATA_W    = 8,
   parameter int              LANES     = 2,
   parameter logic [ADDR_W-1:0] LO_ADDR   = 8'h82,
   parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h85
) (
   input  logic [ADDR_W-1:0]       addr,
   input  logic [DATA_W-1:0]       ctrl_byte,
   input  logic [LANES*DATA_W-1:0] active,
   output logic [DATA_W-1:0]       rdata
);

   logic [LANES-1:0] hit;

   for (genvar b = 0; b < LANES; b++) begin : g_hit
      localparam logic [ADDR_W-1:0] LANE_ADDR = ADDR_W'(LO_ADDR + b);
      assign hit[b] = (addr == LANE_ADDR);
   end

   always_comb begin
      rdata = '0;
      if (addr == CTRL_ADDR) rdata = ctrl_byte;
      for (int b = 0; b < LANES; b++) begin
         if (hit[b]) rdata = active[b*DATA_W +: DATA_W];
      end
   end

endmodule

// File: rtl/dptr_bank_unit.sv
module dptr_bank_unit
   import dptr_bank_pkg::*;
#(
   parameter int                ADDR_W    = 8,
   parameter int                DATA_W    = 8,
   parameter int                PTR_W     = 16,
   parameter logic [ADDR_W-1:0] LO_ADDR   = 8'h82,
   parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h85
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] sfr_addr,
   input  logic [DATA_W-1:0] sfr_wdata,
   input  logic              sfr_we,
   input  logic              movx_stb,
   output logic [DATA_W-1:0] sfr_rdata,
   output logic [PTR_W-1:0]  xaddr
);

   localparam int LANES = PTR_W / DATA_W;
   localparam logic [DATA_W-1:0] CTRL_MASK =
      DATA_W'((1 << CTRL_SEL_BIT) | (1 << CTRL_TOG_BIT));

   generate
      if ((CTRL_ADDR >= LO_ADDR) && (int'(CTRL_ADDR) < int'(LO_ADDR) + LANES)) begin : g_clash
         $error("dptr_bank_unit: control address overlaps pointer lanes");
      end
   endgenerate

   dptr_ctrl_t                       ctrl;
   logic [NUM_PTR-1:0][PTR_W-1:0]    ptrs;
   logic [LANES-1:0]                 lane_we;
   logic [DATA_W-1:0]                ctrl_byte;
   logic                             ctrl_we;

   assign ctrl_we = sfr_we && (sfr_addr == CTRL_ADDR);

   for (genvar b = 0; b < LANES; b++) begin : g_lane_dec
      localparam logic [ADDR_W-1:0] LANE_ADDR = ADDR_W'(LO_ADDR + b);
      assign lane_we[b] = sfr_we && (sfr_addr == LANE_ADDR);
   end

   dptr_ctrl_reg #(.DATA_W(DATA_W)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (ctrl_we),
      .wdata    (sfr_wdata),
      .movx_stb (movx_stb),
      .ctrl     (ctrl)
   );

   dptr_store #(.NUM_PTR(NUM_PTR), .DATA_W(DATA_W), .PTR_W(PTR_W)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .sel     (ctrl.sel),
      .lane_we (lane_we),
      .wdata   (sfr_wdata),
      .ptrs    (ptrs)
   );

   always_comb begin
      ctrl_byte               = '0;
      ctrl_byte[CTRL_SEL_BIT] = ctrl.sel;
      ctrl_byte[CTRL_TOG_BIT] = ctrl.toggle_en;
   end

   assign xaddr = ptrs[ctrl.sel];

   dptr_rd_mux #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES),
      .LO_ADDR(LO_ADDR), .CTRL_ADDR(CTRL_ADDR)
   ) u_rd (
      .addr      (sfr_addr),
      .ctrl_byte (ctrl_byte),
      .active    (xaddr),
      .rdata     (sfr_rdata)
   );

   assert_rsvd_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (sfr_addr == CTRL_ADDR) |-> ((sfr_rdata & ~CTRL_MASK) == '0));

   assert_unmapped_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ((sfr_addr != CTRL_ADDR) &&
       ((sfr_addr < LO_ADDR) || (int'(sfr_addr) >= int'(LO_ADDR) + LANES)))
      |-> (sfr_rdata == '0));

   assert_ctrl_view_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (sfr_addr == CTRL_ADDR) |-> (sfr_rdata[CTRL_SEL_BIT] == ctrl.sel));

endmodule

// File: tb/dptr_bank_unit_test.sv
`timescale 1ns/1ps
module dptr_bank_unit_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] sfr_addr = 8'h00;
   logic [7:0] sfr_wdata = 8'h00;
   logic       sfr_we = 1'b0;
   logic       movx_stb = 1'b0;
   logic [7:0] sfr_rdata;
   logic [15:0] xaddr;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   int m_ptr[2];
   int m_sel;
   int m_at;

   always #2.5 clk = ~clk;

   dptr_bank_unit uut (
      .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata),
      .sfr_we(sfr_we), .movx_stb(movx_stb), .sfr_rdata(sfr_rdata), .xaddr(xaddr)
   );

   function automatic int model_read(int a);
      if (a == 'h82) return m_ptr[m_sel] & 'hFF;
      if (a == 'h83) return (m_ptr[m_sel] >> 8) & 'hFF;
      if (a == 'h85) return (m_at << 6) | m_sel;
      return 0;
   endfunction

   task automatic check(string tag, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   // Drive one cycle, compare outputs against the model, then advance the model.
   task automatic step(int a, int wd, bit we, bit mv, string tag);
      int old_sel;
      @(negedge clk);
      sfr_addr = 8'(a); sfr_wdata = 8'(wd); sfr_we = we; movx_stb = mv;
      #1;
      check(tag, "rdata", int'(sfr_rdata), model_read(a));
      check("R8", "xaddr", int'(xaddr), m_ptr[m_sel]);
      @(posedge clk);
      old_sel = m_sel;
      if (we && a == 'h85) begin
         m_sel = wd & 1; m_at = (wd >> 6) & 1;
      end else if (mv && m_at == 1) begin
         m_sel = 1 - m_sel;
      end
      if (we && a == 'h82) m_ptr[old_sel] = (m_ptr[old_sel] & 'hFF00) | (wd & 'hFF);
      if (we && a == 'h83) m_ptr[old_sel] = (m_ptr[old_sel] & 'h00FF) | ((wd & 'hFF) << 8);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      m_ptr[0] = 0; m_ptr[1] = 0; m_sel = 0; m_at = 0;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      // R1: reset values
      step('h85, 0, 0, 0, "R1");
      step('h82, 0, 0, 0, "R1");
      step('h83, 0, 0, 0, "R1");
      // R3: load pointer 0
      step('h82, 'h34, 1, 0, "R3");
      step('h83, 'h12, 1, 0, "R3");
      step('h82, 0, 0, 0, "R2");
      // R2: select pointer 1 and load it
      step('h85, 'h01, 1, 0, "R2");
      step('h82, 0, 0, 0, "R2");
      step('h82, 'hCD, 1, 0, "R3");
      step('h83, 'hAB, 1, 0, "R3");
      step('h83, 0, 0, 0, "R3");
      step('h85, 'h00, 1, 0, "R2");
      step('h83, 0, 0, 0, "R3");
      step('h82, 0, 0, 0, "R3");
      // R4: reserved bits
      step('h85, 'hFF, 1, 0, "R4");
      step('h85, 0, 0, 0, "R4");
      step('h82, 0, 0, 0, "R4");
      // R5: auto toggle on MOVX, back to back and spaced
      step('h85, 0, 0, 1, "R5");
      step('h85, 0, 0, 1, "R5");
      step('h85, 0, 0, 1, "R5");
      step('h83, 0, 0, 0, "R5");
      step('h85, 0, 0, 1, "R5");
      step('h82, 0, 0, 0, "R5");
      // R5: pointer write during toggle lands in the old pointer
      step('h82, 'h77, 1, 1, "R5");
      step('h82, 0, 0, 0, "R5");
      step('h85, 'h40, 1, 0, "R5");
      step('h82, 0, 0, 0, "R5");
      // R7: control write colliding with a toggling MOVX
      step('h85, 'h40, 1, 1, "R7");
      step('h85, 0, 0, 0, "R7");
      step('h85, 'h41, 1, 1, "R7");
      step('h85, 0, 0, 0, "R7");
      // R6: toggle disabled
      step('h85, 'h01, 1, 0, "R6");
      step('h85, 0, 0, 1, "R6");
      step('h85, 0, 0, 1, "R6");
      step('h83, 0, 0, 0, "R6");
      // R9: unmapped addresses
      step('h80, 'h5A, 1, 0, "R9");
      step('h84, 'hA5, 1, 0, "R9");
      step('h86, 'hFF, 1, 0, "R9");
      step('h82, 0, 0, 0, "R9");
      step('h85, 0, 0, 0, "R9");
      step('h85, 'h00, 1, 0, "R9");
      step('h83, 0, 0, 0, "R9");
      step('h00, 0, 0, 0, "R9");
      // R1: reset again mid-run
      @(negedge clk) rst_n = 1'b0;
      m_ptr[0] = 0; m_ptr[1] = 0; m_sel = 0; m_at = 0;
      @(negedge clk) rst_n = 1'b1;
      step('h85, 0, 0, 0, "R1");
      step('h83, 0, 0, 0, "R1");
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule